// File: doc/BRIEF.md
# BCD Time-of-Day and Date Counter

This block keeps a running calendar in packed BCD: seconds, minutes, hours, a weekday number, day of month, month and a three-digit year. A prescaler divides the reference clock by a parameter, 32768 by default, and produces one advance per second. The calendar handles every carry from seconds up to the year. That includes the Gregorian rules for month length and leap years.

A master enable gates the whole block. When it is low the calendar holds and field writes are dropped. When it rises, the prescaler starts counting again from zero. Software or a bus front end selects a field with a 3-bit code for both writing and reading. A one-cycle strobe marks each advance so that alarm logic can compare against the new time.

Top module: `bcd_calendar`

## Requirements
- R1: While `run_en` is high, `sec_pulse` is high for exactly one cycle every PRESCALE cycles. In the clock edge where `run_en` is first sampled high after being low, the prescaler restarts. The first strobe is then visible PRESCALE edges later, and the advanced time is readable in the same cycle as the strobe.
- R2: Seconds and minutes count in BCD 00..59 and hours 00..23. Each wraps to 00 and carries into the next field; a BCD low digit of 9 carries into the tens digit.
- R3: The weekday (selector 3, values 0..6) advances whenever the day of month advances and wraps from 6 to 0.
- R4: The day of month runs from 01 up to the month length: 31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for months 04, 06, 09 and 11; 28 for February in a common year.
- R5: February has 29 days in a leap year. A year is a leap year if it is divisible by 4, except when it is divisible by 100 and not also by 400. Year 000 counts as a leap year.
- R6: After the last day of a month, the day returns to 01 and the month advances. Month counts 01..12 in BCD and wraps from 12 to 01, carrying into the year.
- R7: The year holds three BCD digits, hundreds in bits 11:8, tens in 7:4 and ones in 3:0. It wraps from 999 to 000.
- R8: Field selector codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year. `rd_data` returns the selected field zero-extended, and selector 7 reads 0.
- R9: A write (`wr_en` high) is ignored while `run_en` is low.
- R10: While `run_en` is low, no strobe occurs and no field changes.
- R11: A write in the same cycle as a strobe takes priority over that field's increment. Carries from the field's old value still propagate into the fields above it.
- R12: After reset the calendar reads 00:00:00, weekday 0, day 01, month 01, year 000, with `run_en` treated as low and `sec_pulse` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Master enable; gates counting and writes |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selected for writing |
| wr_data | input | 12 | BCD value to write, low bits used per field |
| rd_sel | input | 3 | Field selected for readback |
| rd_data | output | 12 | Selected field, zero-extended BCD |
| sec_pulse | output | 1 | One-cycle strobe per second advance |

## Verification
The hardest situation to reach is a cascade of carries that depends on the date, such as 23:59:59 on the last day of February, December or the year 999. At run rate, waiting for one of these would take an impractical number of cycles. The bench therefore sets PRESCALE to 16. For each case it restarts the enable, loads every field inside the first prescaler period, and reads all fields back in the strobe cycle. Write-versus-strobe priority needs a write aligned to the strobe edge. The bench reaches it by counting edges from the enable rise.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

    localparam int SEL_W  = 3;
    localparam int DATA_W = 12;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_WDAY = 3'd3,
        FLD_MDAY = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6
    } field_e;

    typedef struct packed {
        logic [6:0]  sec;
        logic [6:0]  min;
        logic [5:0]  hour;
        logic [2:0]  wday;
        logic [5:0]  mday;
        logic [4:0]  mon;
        logic [11:0] year;
    } cal_t;

    typedef struct packed {
        cal_t cal;
        logic pulse;
    } cal_state_t;

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          en_d, en_q;

    always_comb begin
        en_d  = run;
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (run && !en_q) begin
            cnt_d = '0;
        end else if (run) begin
            if (cnt_q == LAST) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            en_q  <= en_d;
        end
    end
endmodule

// File: rtl/bcd_step.sv
module bcd_step #(
    parameter int ND = 3
) (
    input  logic [4*ND-1:0] val,
    input  logic [4*ND-1:0] lo,
    input  logic [4*ND-1:0] hi,
    input  logic            inc,
    output logic [4*ND-1:0] nxt,
    output logic            wrap
);
    logic [4*ND-1:0] plus1;

    always_comb begin
        logic carry;
        carry = 1'b1;
        plus1 = val;
        for (int d = 0; d < ND; d++) begin
            if (carry) begin
                if (val[d*4 +: 4] >= 4'd9) begin
                    plus1[d*4 +: 4] = 4'd0;
                end else begin
                    plus1[d*4 +: 4] = val[d*4 +: 4] + 4'd1;
                    carry = 1'b0;
                end
            end
        end
    end

    // Packed BCD compares like binary for valid digits; >= also recovers
    // from an out-of-range value written by software.
    assign wrap = inc && (val >= hi);
    assign nxt  = !inc ? val : (wrap ? lo : plus1);
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
    input  logic [4:0]  mon,
    input  logic [11:0] year,
    output logic [5:0]  last_day
);
    logic [3:0] y_h, y_t, y_o;
    logic       div4, div100, h_mult4, leap;

    assign y_h = year[11:8];
    assign y_t = year[7:4];
    assign y_o = year[3:0];

    always_comb begin
        if (y_t[0]) div4 = (y_o == 4'd2) || (y_o == 4'd6);
        else        div4 = (y_o == 4'd0) || (y_o == 4'd4) || (y_o == 4'd8);
        div100  = (y_t == 4'd0) && (y_o == 4'd0);
        h_mult4 = (y_h == 4'd0) || (y_h == 4'd4) || (y_h == 4'd8);
        leap    = div4 && (!div100 || h_mult4);
        case (mon)
            5'h02:                      last_day = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_calendar_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              sec_pulse
);
    localparam int ND = DATA_W / 4;
    localparam logic [DATA_W-1:0] Z = '0;

    cal_state_t st_d, st_q;
    logic       tick;
    logic [5:0] mlen;

    logic [DATA_W-1:0] sec_n, min_n, hour_n, wday_n, mday_n, mon_n, year_n;
    logic              sec_w, min_w, hour_w, wday_w, mday_w, mon_w, year_w;

    cal_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_en), .tick(tick)
    );

    cal_month_len u_mlen (
        .mon(st_q.cal.mon), .year(st_q.cal.year), .last_day(mlen)
    );

    bcd_step #(.ND(ND)) u_sec (
        .val({5'd0, st_q.cal.sec}), .lo(Z), .hi(12'h059), .inc(tick),
        .nxt(sec_n), .wrap(sec_w)
    );
    bcd_step #(.ND(ND)) u_min (
        .val({5'd0, st_q.cal.min}), .lo(Z), .hi(12'h059), .inc(sec_w),
        .nxt(min_n), .wrap(min_w)
    );
    bcd_step #(.ND(ND)) u_hour (
        .val({6'd0, st_q.cal.hour}), .lo(Z), .hi(12'h023), .inc(min_w),
        .nxt(hour_n), .wrap(hour_w)
    );
    bcd_step #(.ND(ND)) u_wday (
        .val({9'd0, st_q.cal.wday}), .lo(Z), .hi(12'h006), .inc(hour_w),
        .nxt(wday_n), .wrap(wday_w)
    );
    bcd_step #(.ND(ND)) u_mday (
        .val({6'd0, st_q.cal.mday}), .lo(12'h001), .hi({6'd0, mlen}),
        .inc(hour_w), .nxt(mday_n), .wrap(mday_w)
    );
    bcd_step #(.ND(ND)) u_mon (
        .val({7'd0, st_q.cal.mon}), .lo(12'h001), .hi(12'h012), .inc(mday_w),
        .nxt(mon_n), .wrap(mon_w)
    );
    bcd_step #(.ND(ND)) u_year (
        .val(st_q.cal.year), .lo(Z), .hi(12'h999), .inc(mon_w),
        .nxt(year_n), .wrap(year_w)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pulse    = tick;
        st_d.cal.sec  = sec_n[6:0];
        st_d.cal.min  = min_n[6:0];
        st_d.cal.hour = hour_n[5:0];
        st_d.cal.wday = wday_n[2:0];
        st_d.cal.mday = mday_n[5:0];
        st_d.cal.mon  = mon_n[4:0];
        st_d.cal.year = year_n;
        if (wr_en && run_en) begin
            case (wr_sel)
                FLD_SEC:  st_d.cal.sec  = wr_data[6:0];
                FLD_MIN:  st_d.cal.min  = wr_data[6:0];
                FLD_HOUR: st_d.cal.hour = wr_data[5:0];
                FLD_WDAY: st_d.cal.wday = wr_data[2:0];
                FLD_MDAY: st_d.cal.mday = wr_data[5:0];
                FLD_MON:  st_d.cal.mon  = wr_data[4:0];
                FLD_YEAR: st_d.cal.year = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cal.mday <= 6'h01;
            st_q.cal.mon  <= 5'h01;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_sel)
            FLD_SEC:  rd_data = {5'd0, st_q.cal.sec};
            FLD_MIN:  rd_data = {5'd0, st_q.cal.min};
            FLD_HOUR: rd_data = {6'd0, st_q.cal.hour};
            FLD_WDAY: rd_data = {9'd0, st_q.cal.wday};
            FLD_MDAY: rd_data = {6'd0, st_q.cal.mday};
            FLD_MON:  rd_data = {7'd0, st_q.cal.mon};
            FLD_YEAR: rd_data = st_q.cal.year;
            default:  rd_data = '0;
        endcase
    end

    assign sec_pulse = st_q.pulse;
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
    import bcd_calendar_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic             sec_pulse,
    input cal_t             cal
);
    // R1
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    // R10
    no_pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !sec_pulse);

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(cal));

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && $past(cal.sec == 7'h59 && !(wr_en && run_en && wr_sel == FLD_SEC)))
        |-> (cal.sec == 7'h00));

    // R7
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && $past(!wr_en && cal.year == 12'h999 && cal.mon == 5'h12 &&
                            cal.mday == 6'h31 && cal.hour == 6'h23 &&
                            cal.min == 7'h59 && cal.sec == 7'h59))
        |-> (cal.year == 12'h000 && cal.mon == 5'h01 && cal.mday == 6'h01));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .sec_pulse(sec_pulse), .cal(st_q.cal)
);

// File: tb/bcd_calendar_bench.sv
`timescale 1ns/1ps
module bcd_calendar_bench;
    localparam int PRE = 16;
    localparam int NV  = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [11:0] rd_data;
    logic        sec_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bcd_calendar #(.PRESCALE(PRE)) u_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .sec_pulse(sec_pulse)
    );

    // field order: sec, min, hour, wday, mday, mon, year
    localparam logic [11:0] VIN [NV][7] = '{
        '{12'h00, 12'h00, 12'h00, 12'h0, 12'h01, 12'h01, 12'h000},
        '{12'h59, 12'h59, 12'h23, 12'h6, 12'h31, 12'h12, 12'h999},
        '{12'h59, 12'h59, 12'h23, 12'h2, 12'h28, 12'h02, 12'h024},
        '{12'h59, 12'h59, 12'h23, 12'h3, 12'h29, 12'h02, 12'h024},
        '{12'h59, 12'h59, 12'h23, 12'h1, 12'h28, 12'h02, 12'h100},
        '{12'h59, 12'h59, 12'h23, 12'h1, 12'h28, 12'h02, 12'h400},
        '{12'h59, 12'h59, 12'h23, 12'h5, 12'h30, 12'h04, 12'h123},
        '{12'h09, 12'h00, 12'h00, 12'h0, 12'h01, 12'h01, 12'h000},
        '{12'h59, 12'h09, 12'h05, 12'h0, 12'h01, 12'h01, 12'h000},
        '{12'h59, 12'h59, 12'h19, 12'h4, 12'h15, 12'h07, 12'h555},
        '{12'h59, 12'h59, 12'h23, 12'h2, 12'h31, 12'h12, 12'h099},
        '{12'h59, 12'h59, 12'h23, 12'h0, 12'h28, 12'h02, 12'h023},
        '{12'h59, 12'h59, 12'h23, 12'h0, 12'h31, 12'h01, 12'h200},
        '{12'h59, 12'h59, 12'h23, 12'h0, 12'h30, 12'h09, 12'h000}
    };
    localparam logic [11:0] VEXP [NV][7] = '{
        '{12'h01, 12'h00, 12'h00, 12'h0, 12'h01, 12'h01, 12'h000},
        '{12'h00, 12'h00, 12'h00, 12'h0, 12'h01, 12'h01, 12'h000},
        '{12'h00, 12'h00, 12'h00, 12'h3, 12'h29, 12'h02, 12'h024},
        '{12'h00, 12'h00, 12'h00, 12'h4, 12'h01, 12'h03, 12'h024},
        '{12'h00, 12'h00, 12'h00, 12'h2, 12'h01, 12'h03, 12'h100},
        '{12'h00, 12'h00, 12'h00, 12'h2, 12'h29, 12'h02, 12'h400},
        '{12'h00, 12'h00, 12'h00, 12'h6, 12'h01, 12'h05, 12'h123},
        '{12'h10, 12'h00, 12'h00, 12'h0, 12'h01, 12'h01, 12'h000},
        '{12'h00, 12'h10, 12'h05, 12'h0, 12'h01, 12'h01, 12'h000},
        '{12'h00, 12'h00, 12'h20, 12'h4, 12'h15, 12'h07, 12'h555},
        '{12'h00, 12'h00, 12'h00, 12'h3, 12'h01, 12'h01, 12'h100},
        '{12'h00, 12'h00, 12'h00, 12'h1, 12'h01, 12'h03, 12'h023},
        '{12'h00, 12'h00, 12'h00, 12'h1, 12'h01, 12'h02, 12'h200},
        '{12'h00, 12'h00, 12'h00, 12'h1, 12'h01, 12'h10, 12'h000}
    };

    function automatic string tag_of(int f);
        case (f)
            0, 1, 2: return "R2 R8";
            3:       return "R3";
            4:       return "R4 R5";
            5:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [11:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    // restart: run_en low for one edge, then high; returns at the negedge
    // just before the edge that first samples run_en high
    task automatic restart();
        @(negedge clk) run_en = 1'b0;
        @(negedge clk) run_en = 1'b1;
    endtask

    initial begin
        logic [11:0] v;
        // R12 reset state
        repeat (3) @(negedge clk);
        check("R12 pulse", {11'd0, sec_pulse}, 12'h0);
        for (int f = 0; f < 7; f++) begin
            rd(3'(f), v);
            check("R12", v, (f == 4 || f == 5) ? 12'h001 : 12'h000);
        end
        rst_n = 1'b1;

        // vector table, R1 timing of first strobe after enable rise
        for (int i = 0; i < NV; i++) begin
            restart();
            for (int f = 0; f < 7; f++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_sel = 3'(f); wr_data = VIN[i][f];
            end
            @(negedge clk) wr_en = 1'b0;           // negedge 8
            repeat (PRE - 8) @(negedge clk);       // negedge PRE
            check("R1 early", {11'd0, sec_pulse}, 12'h0);
            @(negedge clk);                        // negedge PRE+1
            check("R1 strobe", {11'd0, sec_pulse}, 12'h1);
            for (int f = 0; f < 7; f++) begin
                rd(3'(f), v);
                check(tag_of(f), v, VEXP[i][f]);
            end
        end

        // R8 unused selector reads zero
        rd(3'd7, v);
        check("R8 sel7", v, 12'h000);

        // R1 period and width, R1 restart on enable rise
        restart();
        repeat (10) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk) run_en = 1'b1;
        repeat (PRE) @(negedge clk);
        check("R1 restart early", {11'd0, sec_pulse}, 12'h0);
        @(negedge clk);
        check("R1 restart", {11'd0, sec_pulse}, 12'h1);
        @(negedge clk);
        check("R1 width", {11'd0, sec_pulse}, 12'h0);
        repeat (PRE - 2) @(negedge clk);
        check("R1 period early", {11'd0, sec_pulse}, 12'h0);
        @(negedge clk);
        check("R1 period", {11'd0, sec_pulse}, 12'h1);

        // R11 write aligned with strobe edge
        restart();
        @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h059;
        @(negedge clk); wr_sel = 3'd1; wr_data = 12'h010;
        @(negedge clk); wr_en = 1'b0;              // negedge 3
        repeat (PRE - 3) @(negedge clk);           // negedge PRE
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h005;
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 strobe", {11'd0, sec_pulse}, 12'h1);
        rd(3'd0, v); check("R11 sec", v, 12'h005);
        rd(3'd1, v); check("R11 carry", v, 12'h011);

        // R9 / R10 disabled: writes dropped, no advance, no strobe
        begin
            logic [11:0] s0;
            int seen;
            seen = 0;
            @(negedge clk) run_en = 1'b0;
            rd(3'd0, s0);
            wr_en = 1'b1; wr_sel = 3'd0; wr_data = 12'h045;
            @(negedge clk) wr_en = 1'b0;
            rd(3'd0, v); check("R9 write ignored", v, s0);
            for (int k = 0; k < 3 * PRE; k++) begin
                @(negedge clk);
                if (sec_pulse) seen++;
            end
            check("R10 no strobe", 12'(seen), 12'h0);
            rd(3'd0, v); check("R10 held", v, s0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule